// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block compares every instruction fetch, load and store of a hart against a small set of programmable debug triggers. For each access it receives the access kind, the address, the data, the current privilege level, a narrow-mode flag and a debug-mode flag. It also receives the configuration word and the compare value of every trigger. It reports whether a trigger fired and which one fired. The trap or debug-entry logic around it uses that result to decide what happens to the access.

Each trigger filters on access kind and privilege level. It then compares either the address or the data against its compare value, using one of six modes: equality, unsigned greater-or-equal, unsigned less-than, a naturally aligned power-of-two range, and two half-width masked compares. Triggers can be linked into chains. A chain reports only when every linked trigger hits, and the index it reports is that of the chain's last member. The decision is combinational. An optional output register adds one cycle of latency and is enabled by default.

Top module: `trig_match_unit`

## Requirements
- R1: During reset both outputs are 0. Whenever `hit_o` is 0, `idx_o` is 0. With `REG_OUT`=1, the outputs reflect the inputs of the previous clock edge.
- R2: Access kind encoding: 0 is execute, 1 is load, 2 is store, 3 is no access. A trigger takes part only if its enable bit for the current kind is set: configuration bit 0 for execute, bit 1 for load, bit 2 for store. Kind 3 never produces a hit.
- R3: Privilege encoding: 0 is U, 1 is S, 2 is H, 3 is M. A trigger takes part only if configuration bit 3+privilege is set.
- R4: When configuration bit 7 is 1, the trigger compares the access data. Otherwise it compares the address.
- R5: When `narrow_i` is 1, the compared value and the compare value are both cut to their low 32 bits. In that case the masked modes use a 16-bit half.
- R6: Mode field is configuration bits 11:9. Mode 0 (equal) hits when the value equals the compare value.
- R7: Mode 2 hits when value >= compare value. Mode 3 hits when value < compare value. Both comparisons are unsigned.
- R8: Mode 1 (power-of-two range) counts the run of 1 bits at the bottom of the compare value. It clears that many low bits in both operands and hits if the rest are equal.
- R9: Mode 4 uses the upper half of the compare value as a mask and hits when the lower half of the value equals the lower half of the compare value under that mask. Mode 5 does the same with the upper half of the value.
- R10: Configuration bit 8 is the chain bit. A hitting trigger with this bit set passes evaluation to the next trigger. A hit is reported only at the first unchained trigger that also hits, with that trigger's index. A chain whose last member is chained never reports.
- R11: A miss inside a chain skips every following trigger up to and including the next unchained one. Evaluation then resumes after it.
- R12: While `dbg_mode_i` is 1, no hit is reported.
- R13: Among independent hits, the lowest index is reported. Mode codes 6 and 7 never hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| narrow_i | input | 1 | 32-bit mode: compare on the low 32 bits only |
| dbg_mode_i | input | 1 | Hart is in debug mode; suppresses all hits |
| kind_i | input | 2 | Access kind (execute, load, store, none) |
| priv_i | input | 2 | Current privilege level |
| addr_i | input | XLEN | Access address |
| data_i | input | XLEN | Access data |
| cfg_i | input | NUM_TRIG*12 | Per-trigger configuration, trigger n at bits 12n+11:12n |
| cmp_i | input | NUM_TRIG*XLEN | Per-trigger compare value, trigger n at slice n |
| hit_o | output | 1 | A trigger fired |
| idx_o | output | clog2(NUM_TRIG) | Index of the trigger that fired |

## Verification
On every cycle, the bound checker verifies the following. Debug mode and the no-access kind never lead to a hit. The index is zero whenever there is no hit. The reported trigger is unchained and enabled for the access kind and privilege that produced the result. Numeric behaviour needs the bench's directed scenarios: each compare mode at and around its boundaries, narrow-mode truncation, the choice between address and data, priority, and chained hit, chained miss and resume-after-skip.

// File: rtl/trig_match_pkg.sv
`timescale 1ns/1ps
package trig_match_pkg;

    localparam int CFG_W = 12;

    typedef enum logic [1:0] {
        ACC_EXEC  = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        CMP_EQ   = 3'd0,
        CMP_POW2 = 3'd1,
        CMP_GE   = 3'd2,
        CMP_LT   = 3'd3,
        CMP_MLO  = 3'd4,
        CMP_MHI  = 3'd5
    } cmp_mode_e;

    // bit 0 ex_en ... bit 11 top of mode; priv_en[p] sits at bit 3+p
    typedef struct packed {
        logic [2:0] mode;
        logic       chain;
        logic       sel_data;
        logic [3:0] priv_en;
        logic       st_en;
        logic       ld_en;
        logic       ex_en;
    } trig_cfg_t;

    typedef struct packed {
        logic       hit;
        logic [7:0] idx;
    } trig_res_t;

endpackage

// File: rtl/trig_value_cmp.sv
`timescale 1ns/1ps
module trig_value_cmp #(
    parameter int XLEN = 64
) (
    input  logic [2:0]      mode_i,
    input  logic            narrow_i,
    input  logic [XLEN-1:0] val_i,
    input  logic [XLEN-1:0] cmp_i,
    output logic            hit_o
);
    import trig_match_pkg::*;

    localparam int HALF   = XLEN / 2;
    localparam int N_W    = 32;
    localparam int N_HALF = N_W / 2;

    logic [XLEN-1:0] low_ones;
    logic            eq_hit, ge_hit, lt_hit, pow_hit;
    logic            mlo_w, mhi_w, mlo_n, mhi_n;

    always_comb begin
        low_ones = cmp_i & ~(cmp_i + XLEN'(1));
        eq_hit   = (val_i == cmp_i);
        ge_hit   = (val_i >= cmp_i);
        lt_hit   = (val_i <  cmp_i);
        pow_hit  = (((val_i ^ cmp_i) & ~low_ones) == '0);
        mlo_w    = (((val_i[HALF-1:0]    ^ cmp_i[HALF-1:0]) & cmp_i[XLEN-1:HALF]) == '0);
        mhi_w    = (((val_i[XLEN-1:HALF] ^ cmp_i[HALF-1:0]) & cmp_i[XLEN-1:HALF]) == '0);
        mlo_n    = (((val_i[N_HALF-1:0]  ^ cmp_i[N_HALF-1:0]) & cmp_i[N_W-1:N_HALF]) == '0);
        mhi_n    = (((val_i[N_W-1:N_HALF] ^ cmp_i[N_HALF-1:0]) & cmp_i[N_W-1:N_HALF]) == '0);
        unique case (mode_i)
            CMP_EQ:   hit_o = eq_hit;
            CMP_POW2: hit_o = pow_hit;
            CMP_GE:   hit_o = ge_hit;
            CMP_LT:   hit_o = lt_hit;
            CMP_MLO:  hit_o = narrow_i ? mlo_n : mlo_w;
            CMP_MHI:  hit_o = narrow_i ? mhi_n : mhi_w;
            default:  hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/trig_slot.sv
`timescale 1ns/1ps
module trig_slot #(
    parameter int XLEN = 64
) (
    input  trig_match_pkg::trig_cfg_t cfg_i,
    input  logic [XLEN-1:0]           cmp_i,
    input  logic [XLEN-1:0]           addr_i,
    input  logic [XLEN-1:0]           data_i,
    input  logic                      narrow_i,
    input  logic [1:0]                kind_i,
    input  logic [1:0]                priv_i,
    output logic                      hit_o
);
    import trig_match_pkg::*;

    logic            kind_ok, priv_ok, val_hit;
    logic [XLEN-1:0] val_sel, val_eff, cmp_eff;

    always_comb begin
        unique case (kind_i)
            ACC_EXEC:  kind_ok = cfg_i.ex_en;
            ACC_LOAD:  kind_ok = cfg_i.ld_en;
            ACC_STORE: kind_ok = cfg_i.st_en;
            default:   kind_ok = 1'b0;
        endcase
        priv_ok = cfg_i.priv_en[priv_i];
        val_sel = cfg_i.sel_data ? data_i : addr_i;
        val_eff = val_sel;
        cmp_eff = cmp_i;
        if (narrow_i) begin
            val_eff = XLEN'(val_sel[31:0]);
            cmp_eff = XLEN'(cmp_i[31:0]);
        end
    end

    trig_value_cmp #(.XLEN(XLEN)) i_cmp (
        .mode_i   (cfg_i.mode),
        .narrow_i (narrow_i),
        .val_i    (val_eff),
        .cmp_i    (cmp_eff),
        .hit_o    (val_hit)
    );

    assign hit_o = kind_ok & priv_ok & val_hit;

endmodule

// File: rtl/trig_chain_resolve.sv
`timescale 1ns/1ps
module trig_chain_resolve #(
    parameter int NUM_TRIG = 4,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_TRIG-1:0] slot_hit_i,
    input  logic [NUM_TRIG-1:0] chain_i,
    input  logic                block_i,
    output logic                hit_o,
    output logic [IDX_W-1:0]    idx_o
);

    logic link_ok;
    logic found;

    always_comb begin
        link_ok = 1'b1;
        found   = 1'b0;
        hit_o   = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (!found) begin
                if (!link_ok) begin
                    link_ok = !chain_i[i];
                end else if (slot_hit_i[i]) begin
                    if (!chain_i[i]) begin
                        hit_o = 1'b1;
                        idx_o = IDX_W'(i);
                        found = 1'b1;
                    end
                end else begin
                    link_ok = !chain_i[i];
                end
            end
        end
        if (block_i) begin
            hit_o = 1'b0;
            idx_o = '0;
        end
    end

endmodule

// File: rtl/trig_match_unit.sv
`timescale 1ns/1ps
module trig_match_unit #(
    parameter int XLEN     = 64,
    parameter int NUM_TRIG = 4,
    parameter bit REG_OUT  = 1'b1,
    localparam int CFG_W   = trig_match_pkg::CFG_W,
    localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      narrow_i,
    input  logic                      dbg_mode_i,
    input  logic [1:0]                kind_i,
    input  logic [1:0]                priv_i,
    input  logic [XLEN-1:0]           addr_i,
    input  logic [XLEN-1:0]           data_i,
    input  logic [NUM_TRIG*CFG_W-1:0] cfg_i,
    input  logic [NUM_TRIG*XLEN-1:0]  cmp_i,
    output logic                      hit_o,
    output logic [IDX_W-1:0]          idx_o
);
    import trig_match_pkg::*;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } out_t;

    trig_cfg_t            slot_cfg [NUM_TRIG];
    logic [NUM_TRIG-1:0]  slot_hit;
    logic [NUM_TRIG-1:0]  slot_chain;
    logic                 res_hit;
    logic [IDX_W-1:0]     res_idx;
    out_t                 out_d, out_q;

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
        assign slot_cfg[g]   = trig_cfg_t'(cfg_i[g*CFG_W +: CFG_W]);
        assign slot_chain[g] = slot_cfg[g].chain;
        trig_slot #(.XLEN(XLEN)) i_slot (
            .cfg_i    (slot_cfg[g]),
            .cmp_i    (cmp_i[g*XLEN +: XLEN]),
            .addr_i   (addr_i),
            .data_i   (data_i),
            .narrow_i (narrow_i),
            .kind_i   (kind_i),
            .priv_i   (priv_i),
            .hit_o    (slot_hit[g])
        );
    end

    trig_chain_resolve #(.NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) i_resolve (
        .slot_hit_i (slot_hit),
        .chain_i    (slot_chain),
        .block_i    (dbg_mode_i),
        .hit_o      (res_hit),
        .idx_o      (res_idx)
    );

    always_comb begin
        out_d     = '0;
        out_d.hit = res_hit;
        out_d.idx = res_hit ? res_idx : '0;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) out_q <= '0;
            else         out_q <= out_d;
        end
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign hit_o = out_q.hit;
    assign idx_o = out_q.idx;

endmodule

// File: rtl/trig_match_chk.sv
`timescale 1ns/1ps
module trig_match_chk #(
    parameter int XLEN     = 64,
    parameter int NUM_TRIG = 4,
    parameter bit REG_OUT  = 1'b1,
    localparam int CFG_W   = trig_match_pkg::CFG_W,
    localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      dbg_mode_i,
    input  logic [1:0]                kind_i,
    input  logic [1:0]                priv_i,
    input  logic [NUM_TRIG*CFG_W-1:0] cfg_i,
    input  logic                      hit_o,
    input  logic [IDX_W-1:0]          idx_o
);
    import trig_match_pkg::*;

    logic                      seen_dbg;
    logic [1:0]                seen_kind, seen_priv;
    logic [NUM_TRIG*CFG_W-1:0] seen_cfg;
    trig_cfg_t                 rep_cfg;
    logic                      rep_kind_ok;

    if (REG_OUT) begin : g_seen_q
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                seen_dbg  <= 1'b0;
                seen_kind <= 2'd0;
                seen_priv <= 2'd0;
                seen_cfg  <= '0;
            end else begin
                seen_dbg  <= dbg_mode_i;
                seen_kind <= kind_i;
                seen_priv <= priv_i;
                seen_cfg  <= cfg_i;
            end
        end
    end else begin : g_seen_c
        assign seen_dbg  = dbg_mode_i;
        assign seen_kind = kind_i;
        assign seen_priv = priv_i;
        assign seen_cfg  = cfg_i;
    end

    always_comb begin
        rep_cfg = trig_cfg_t'(seen_cfg[idx_o*CFG_W +: CFG_W]);
        unique case (seen_kind)
            ACC_EXEC:  rep_kind_ok = rep_cfg.ex_en;
            ACC_LOAD:  rep_kind_ok = rep_cfg.ld_en;
            ACC_STORE: rep_kind_ok = rep_cfg.st_en;
            default:   rep_kind_ok = 1'b0;
        endcase
    end

    // R12
    dbg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seen_dbg |-> !hit_o);
    // R2
    no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_kind == ACC_NONE) |-> !hit_o);
    // R1
    idle_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit_o |-> (idx_o == '0));
    // R10
    unchained_rep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> !rep_cfg.chain);
    // R2
    kind_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> rep_kind_ok);
    // R3
    priv_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> rep_cfg.priv_en[seen_priv]);

endmodule

bind trig_match_unit trig_match_chk #(
    .XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .REG_OUT(REG_OUT)
) i_trig_match_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dbg_mode_i (dbg_mode_i),
    .kind_i     (kind_i),
    .priv_i     (priv_i),
    .cfg_i      (cfg_i),
    .hit_o      (hit_o),
    .idx_o      (idx_o)
);

// File: tb/test_trig_match_unit.sv
`timescale 1ns/1ps
module test_trig_match_unit;
    import trig_match_pkg::*;

    localparam int XL = 64;
    localparam int NT = 4;
    localparam int CW = CFG_W;

    typedef struct {
        logic       h;
        logic [1:0] i;
        string      tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              narrow = 1'b0, dbg = 1'b0;
    logic [1:0]        kind = 2'd3, priv = 2'd3;
    logic [XL-1:0]     addr = '0, data = '0;
    logic [NT*CW-1:0]  cfg = '0;
    logic [NT*XL-1:0]  cmp = '0;
    logic              hit;
    logic [1:0]        idx;

    trig_cfg_t         st_cfg [NT];
    logic [XL-1:0]     st_cmp [NT];
    exp_t              q [$];
    int                checks = 0, fails = 0;
    bit                done = 1'b0;

    always #10 clk = ~clk;

    trig_match_unit #(.XLEN(XL), .NUM_TRIG(NT), .REG_OUT(1'b1)) i_trig_match_unit (
        .clk_i(clk), .rst_ni(rst_n), .narrow_i(narrow), .dbg_mode_i(dbg),
        .kind_i(kind), .priv_i(priv), .addr_i(addr), .data_i(data),
        .cfg_i(cfg), .cmp_i(cmp), .hit_o(hit), .idx_o(idx)
    );

    function automatic trig_cfg_t mk(logic ex, logic ld, logic st, logic [3:0] pm,
                                     logic sel, logic chn, logic [2:0] md);
        trig_cfg_t c;
        c.ex_en = ex; c.ld_en = ld; c.st_en = st; c.priv_en = pm;
        c.sel_data = sel; c.chain = chn; c.mode = md;
        return c;
    endfunction

    task automatic clear_all();
        for (int i = 0; i < NT; i++) begin
            st_cfg[i] = '0;
            st_cmp[i] = '0;
        end
    endtask

    task automatic drive(input logic nar, input logic dg, input logic [1:0] k,
                         input logic [1:0] p, input logic [XL-1:0] a,
                         input logic [XL-1:0] d, input logic eh,
                         input logic [1:0] ei, input string tag);
        exp_t e;
        @(negedge clk);
        narrow = nar; dbg = dg; kind = k; priv = p; addr = a; data = d;
        for (int i = 0; i < NT; i++) begin
            cfg[i*CW +: CW] = st_cfg[i];
            cmp[i*XL +: XL] = st_cmp[i];
        end
        e.h = eh; e.i = ei; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: sample 5 ns after each rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (hit !== e.h || idx !== e.i) begin
                    fails++;
                    $display("FAIL %s: hit/idx actual %0b/%0d expected %0b/%0d",
                             e.tag, hit, idx, e.h, e.i);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    localparam logic [3:0] ALL = 4'b1111;
    localparam logic [1:0] K_EX = 2'd0, K_LD = 2'd1, K_ST = 2'd2, K_NO = 2'd3;
    localparam logic [1:0] P_U = 2'd0, P_M = 2'd3;

    initial begin
        clear_all();
        st_cfg[0] = mk(1, 0, 0, ALL, 0, 0, 3'd0);
        st_cmp[0] = 64'h1000;
        for (int i = 0; i < NT; i++) begin
            cfg[i*CW +: CW] = st_cfg[i];
            cmp[i*XL +: XL] = st_cmp[i];
        end
        kind = K_EX; addr = 64'h1000;
        repeat (3) @(negedge clk);
        checks++;
        if (hit !== 1'b0 || idx !== 2'd0) begin
            fails++;
            $display("FAIL R1 reset: hit/idx actual %0b/%0d expected 0/0", hit, idx);
        end
        rst_n = 1'b1;

        // R6 equal / R1 idle index
        drive(0, 0, K_EX, P_M, 64'h1000, 0, 1, 0, "R6 equal hit");
        drive(0, 0, K_EX, P_M, 64'h1004, 0, 0, 0, "R6 equal miss, R1 idx zero");
        // R2 access kind
        drive(0, 0, K_LD, P_M, 64'h1000, 0, 0, 0, "R2 load not enabled");
        drive(0, 0, K_NO, P_M, 64'h1000, 0, 0, 0, "R2 no access");
        // R12 debug mode
        drive(0, 1, K_EX, P_M, 64'h1000, 0, 0, 0, "R12 debug mode");
        // R3 privilege
        clear_all();
        st_cfg[1] = mk(0, 1, 0, 4'b0001, 0, 0, 3'd0);
        st_cmp[1] = 64'h2000;
        drive(0, 0, K_LD, P_M, 64'h2000, 0, 0, 0, "R3 M not enabled");
        drive(0, 0, K_LD, P_U, 64'h2000, 0, 1, 1, "R3 U enabled");
        // R4 select
        clear_all();
        st_cfg[2] = mk(0, 0, 1, ALL, 1, 0, 3'd0);
        st_cmp[2] = 64'hDEAD;
        drive(0, 0, K_ST, P_M, 64'h10, 64'hDEAD, 1, 2, "R4 data hit");
        drive(0, 0, K_ST, P_M, 64'hDEAD, 64'h10, 0, 0, "R4 address ignored");
        // R5 narrow
        clear_all();
        st_cfg[0] = mk(1, 0, 0, ALL, 0, 0, 3'd0);
        st_cmp[0] = 64'h8000_0000;
        drive(1, 0, K_EX, P_M, 64'hFFFF_FFFF_8000_0000, 0, 1, 0, "R5 narrow hit");
        drive(0, 0, K_EX, P_M, 64'hFFFF_FFFF_8000_0000, 0, 0, 0, "R5 wide miss");
        // R7 ge / lt
        st_cfg[0] = mk(1, 0, 0, ALL, 0, 0, 3'd2);
        st_cmp[0] = 64'h100;
        drive(0, 0, K_EX, P_M, 64'h100, 0, 1, 0, "R7 ge equal");
        drive(0, 0, K_EX, P_M, 64'hFF, 0, 0, 0, "R7 ge below");
        drive(0, 0, K_EX, P_M, '1, 0, 1, 0, "R7 ge unsigned top");
        st_cfg[0] = mk(1, 0, 0, ALL, 0, 0, 3'd3);
        drive(0, 0, K_EX, P_M, 64'hFF, 0, 1, 0, "R7 lt below");
        drive(0, 0, K_EX, P_M, 64'h100, 0, 0, 0, "R7 lt equal");
        drive(0, 0, K_EX, P_M, '1, 0, 0, 0, "R7 lt unsigned top");
        // R8 power-of-two range 0x1000..0x1007
        st_cfg[0] = mk(1, 0, 0, ALL, 0, 0, 3'd1);
        st_cmp[0] = 64'h1007;
        drive(0, 0, K_EX, P_M, 64'h1005, 0, 1, 0, "R8 inside");
        drive(0, 0, K_EX, P_M, 64'h1008, 0, 0, 0, "R8 above");
        drive(0, 0, K_EX, P_M, 64'h0FFF, 0, 0, 0, "R8 below");
        // R9 masked
        st_cfg[0] = mk(0, 1, 0, ALL, 0, 0, 3'd4);
        st_cmp[0] = 64'h0000_00FF_0000_0034;
        drive(0, 0, K_LD, P_M, 64'hABCD_1234, 0, 1, 0, "R9 mask low hit");
        drive(0, 0, K_LD, P_M, 64'h35, 0, 0, 0, "R9 mask low miss");
        st_cfg[0] = mk(0, 1, 0, ALL, 0, 0, 3'd5);
        drive(0, 0, K_LD, P_M, 64'h0000_0034_0000_0000, 0, 1, 0, "R9 mask high hit");
        drive(0, 0, K_LD, P_M, 64'h34, 0, 0, 0, "R9 mask high miss");
        st_cfg[0] = mk(0, 1, 0, ALL, 0, 0, 3'd4);
        st_cmp[0] = 64'h00FF_0034;
        drive(1, 0, K_LD, P_M, 64'hFFFF_FFFF_FFFF_1234, 0, 1, 0, "R5 R9 narrow mask low hit");
        drive(1, 0, K_LD, P_M, 64'h1235, 0, 0, 0, "R5 R9 narrow mask low miss");
        // R10 / R11 chaining
        clear_all();
        st_cfg[0] = mk(1, 0, 0, ALL, 0, 1, 3'd0);
        st_cmp[0] = 64'h3000;
        st_cfg[1] = mk(1, 0, 0, ALL, 1, 0, 3'd0);
        st_cmp[1] = 64'h77;
        st_cfg[2] = mk(1, 0, 0, ALL, 0, 0, 3'd0);
        st_cmp[2] = 64'h4000;
        drive(0, 0, K_EX, P_M, 64'h3000, 64'h77, 1, 1, "R10 chain both hit");
        drive(0, 0, K_EX, P_M, 64'h3000, 64'h78, 0, 0, "R10 chain tail miss");
        drive(0, 0, K_EX, P_M, 64'h4000, 64'h77, 1, 2, "R11 skip then resume");
        clear_all();
        st_cfg[3] = mk(1, 0, 0, ALL, 0, 1, 3'd0);
        st_cmp[3] = 64'h5000;
        drive(0, 0, K_EX, P_M, 64'h5000, 0, 0, 0, "R10 open chain at end");
        // R13 priority and unused modes
        clear_all();
        st_cfg[1] = mk(1, 0, 0, ALL, 0, 0, 3'd0);
        st_cmp[1] = 64'h6000;
        st_cfg[3] = mk(1, 0, 0, ALL, 0, 0, 3'd0);
        st_cmp[3] = 64'h6000;
        drive(0, 0, K_EX, P_M, 64'h6000, 0, 1, 1, "R13 lowest index");
        clear_all();
        st_cfg[0] = mk(1, 0, 0, ALL, 0, 0, 3'd6);
        st_cmp[0] = 64'h6000;
        drive(0, 0, K_EX, P_M, 64'h6000, 0, 0, 0, "R13 mode 6");
        st_cfg[0] = mk(1, 0, 0, ALL, 0, 0, 3'd7);
        drive(0, 0, K_EX, P_M, 64'h6000, 0, 0, 0, "R13 mode 7");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule